// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This unit sits next to the access-permission checker of an on-chip bus fabric. Each time the checker rejects an access, it sends the unit a one-cycle pulse. The pulse carries the index of the protected target, the initiator ID, the security domain, the read and write flags, and the full 36-bit address. The unit sets a sticky status bit for that target. An interrupt is raised whenever any status bit is set whose mask bit is clear.

Targets are grouped, `GROUP_SIZE` targets to a group. Each group keeps at most one violation record internally, and a per-group pending bit shows that a record is held. Software does not read the records directly. To service a group, software:

1. Writes a one-hot value to the group-select register.
2. Writes 1 to the shift-control register and polls it until it reads 3. At that point the chosen record has been moved into the two debug registers.
3. Writes 0 to the shift-control register.
4. Clears the pending bit of the group by writing one to it.

Software services the lowest-numbered pending group first.

The register port is a simple single-cycle write strobe. Read data is combinational from the current byte address.

Top module: `vcap_top`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is 0.
- R2: A violation pulse for target t sets bit t%32 of the status word at byte offset 4*(t/32). Writing ones to a status word clears those bits. A violation in the same cycle as a clear of its bit leaves the bit set.
- R3: Mask words sit at offset 0x40+4*i, one bit per target, in the same layout as status. `irq` is high in the cycle after any status bit is set whose mask bit is 0. It is low as long as no such bit exists. Writing all ones to every mask word holds `irq` low.
- R4: A violation sets the pending bit of group t/GROUP_SIZE, which is bit g of offset 0x80. Its details are stored only if that bit was clear. A second violation in a pending group is dropped, and the first record is kept. Writing a one to a bit at 0x80 clears it. A violation in the same cycle as that clear is stored, and the bit stays set.
- R5: The group select at 0x84 is read/write and holds NUM_GROUPS bits. Higher bits read as 0.
- R6: The shift control register is at 0x88. Writing 1 while idle starts a shift, and the register then reads 1. It reads 3 from exactly SHIFT_CYCLES clock edges after the write edge. Writing 0 returns it to 0. Writing 1 while a shift is running or done is ignored.
- R7: When a shift completes, if the select is one-hot and the selected group is pending, that group's record is loaded. Debug word 0 (0x8C) takes initiator in [7:0], domain in [11:8], write in [12], read in [13] and address bits 35:32 in [19:16]. Debug word 1 (0x90) takes address bits 31:0.
- R8: A shift whose select is zero, has more than one bit set, or names a group that is not pending still completes. It leaves both debug words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vioValid | input | 1 | One-cycle violation pulse |
| vioTarget | input | $clog2(NUM_TARGETS) | Index of the protected target |
| vioInitiator | input | 8 | Initiator ID of the rejected access |
| vioDomain | input | 4 | Security domain of the rejected access |
| vioWrite | input | 1 | Rejected access was a write |
| vioRead | input | 1 | Rejected access was a read |
| vioAddr | input | 36 | Full address of the rejected access |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irq | output | 1 | Violation interrupt |

## Verification
Status and pending bits, the stored record and `irq` all change on the edge that samples the pulse. The bench therefore reads them at the following falling edge, plus one time step. The shift is checked on both sides of its boundary:

- control must read 1 after SHIFT_CYCLES-1 edges counted from the write edge;
- control must read 3 after SHIFT_CYCLES edges;
- the debug words are compared in that same done cycle.

All inputs are driven on falling edges, so every register update lands on a known rising edge.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int INIT_W = 8;
  localparam int DOM_W  = 4;
  localparam int AHI_W  = 4;
  localparam int ADDR_W = 32 + AHI_W;
  localparam int WIDX_W = 4;

  localparam int INIT_LSB = 0;
  localparam int DOM_LSB  = 8;
  localparam int WR_BIT   = 12;
  localparam int RD_BIT   = 13;
  localparam int AHI_LSB  = 16;

  localparam logic [7:0] ADDR_MASK_BASE = 8'h40;
  localparam logic [7:0] ADDR_PEND      = 8'h80;
  localparam logic [7:0] ADDR_SEL       = 8'h84;
  localparam logic [7:0] ADDR_CTRL      = 8'h88;
  localparam logic [7:0] ADDR_DBG0      = 8'h8C;
  localparam logic [7:0] ADDR_DBG1      = 8'h90;

  typedef struct packed {
    logic [INIT_W-1:0] initiator;
    logic [DOM_W-1:0]  domain;
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } vio_rec_t;

  typedef struct packed {
    logic              wrStatus;
    logic              wrMask;
    logic              wrPend;
    logic              wrSel;
    logic [WIDX_W-1:0] wordIdx;
    logic [31:0]       wdata;
    logic              shiftDone;
  } strobe_t;

  function automatic logic [31:0] packDbg0(vio_rec_t r);
    logic [31:0] v;
    v = '0;
    v[INIT_LSB +: INIT_W] = r.initiator;
    v[DOM_LSB +: DOM_W]   = r.domain;
    v[WR_BIT]             = r.wr;
    v[RD_BIT]             = r.rd;
    v[AHI_LSB +: AHI_W]   = r.addr[ADDR_W-1:32];
    return v;
  endfunction
endpackage

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int NUM_WORDS    = 2,
  parameter int SHIFT_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output strobe_t     stb,
  output logic [31:0] ctrlRdata
);
  localparam int CNT_W = $clog2(SHIFT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} shift_state_e;

  shift_state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic ctrlWr, ctrlStop, lastBeat, inStatus, inMask;

  assign ctrlWr   = regWrite && (regAddr == ADDR_CTRL);
  assign ctrlStop = ctrlWr && !regWdata[0];
  assign lastBeat = (stateQ == S_BUSY) && (cntQ == LAST_CNT);

  assign inStatus = (regAddr[7:6] == 2'b00) && (regAddr[1:0] == 2'b00) &&
                    (int'(regAddr[5:2]) < NUM_WORDS);
  assign inMask   = (regAddr[7:6] == ADDR_MASK_BASE[7:6]) && (regAddr[1:0] == 2'b00) &&
                    (int'(regAddr[5:2]) < NUM_WORDS);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    if (ctrlStop) begin
      stateD = S_IDLE;
      cntD   = '0;
    end else if (ctrlWr && stateQ == S_IDLE) begin
      stateD = S_BUSY;
      cntD   = '0;
    end else if (stateQ == S_BUSY) begin
      if (lastBeat) stateD = S_DONE;
      else          cntD   = cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    stb.wrStatus  = regWrite && inStatus;
    stb.wrMask    = regWrite && inMask;
    stb.wrPend    = regWrite && (regAddr == ADDR_PEND);
    stb.wrSel     = regWrite && (regAddr == ADDR_SEL);
    stb.wordIdx   = regAddr[5:2];
    stb.wdata     = regWdata;
    stb.shiftDone = lastBeat && !ctrlStop;
  end

  assign ctrlRdata = (regAddr == ADDR_CTRL) ?
                     {30'b0, stateQ == S_DONE, stateQ != S_IDLE} : 32'b0;

  // R6: the beat counter never passes the shift length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BUSY) |-> (cntQ < CNT_W'(SHIFT_CYCLES)));

  // R6: the last beat without a stop always lands in done
  a_r6_done_on_time: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !ctrlStop) |=> (stateQ == S_DONE));

  // R6: a stop write always returns to idle
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStop |=> (stateQ == S_IDLE));

  // R6: a start while running does not restart the count
  a_r6_restart_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BUSY && !lastBeat && ctrlWr && regWdata[0]) |=>
      (stateQ == S_BUSY && cntQ == $past(cntQ) + 1'b1));
endmodule

// File: rtl/vcap_dpath.sv
module vcap_dpath
  import vcap_pkg::*;
#(
  parameter int NUM_TARGETS = 40,
  parameter int GROUP_SIZE  = 8,
  localparam int TGT_W      = $clog2(NUM_TARGETS),
  localparam int NUM_WORDS  = (NUM_TARGETS + 31) / 32,
  localparam int NUM_GROUPS = (NUM_TARGETS + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int BITS       = NUM_WORDS * 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vioValid,
  input  logic [TGT_W-1:0]  vioTarget,
  input  logic [INIT_W-1:0] vioInitiator,
  input  logic [DOM_W-1:0]  vioDomain,
  input  logic              vioWrite,
  input  logic              vioRead,
  input  logic [ADDR_W-1:0] vioAddr,
  input  strobe_t           stb,
  input  logic [7:0]        regAddr,
  output logic [31:0]       dpRdata,
  output logic              irq
);
  logic [BITS-1:0]       statusQ, statusD;
  logic [BITS-1:0]       maskQ, maskD;
  logic [NUM_GROUPS-1:0] pendQ, pendD, pendCleared;
  logic [NUM_GROUPS-1:0] selQ;
  logic [NUM_GROUPS-1:0] capture;
  vio_rec_t              recQ [NUM_GROUPS];
  vio_rec_t              newRec;
  logic [31:0]           dbg0Q, dbg1Q;
  logic                  vioOk;
  int                    vioGroup;
  vio_rec_t              selRec;
  logic                  selHit;

  assign vioOk    = vioValid && (int'(vioTarget) < NUM_TARGETS);
  assign vioGroup = int'(vioTarget) / GROUP_SIZE;
  assign newRec   = '{initiator: vioInitiator, domain: vioDomain,
                      wr: vioWrite, rd: vioRead, addr: vioAddr};

  // status: clear by write, then set by violation (set wins)
  always_comb begin
    statusD = statusQ;
    maskD   = maskQ;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (stb.wrStatus && int'(stb.wordIdx) == w)
        statusD[w*32 +: 32] = statusQ[w*32 +: 32] & ~stb.wdata;
      if (stb.wrMask && int'(stb.wordIdx) == w)
        maskD[w*32 +: 32] = stb.wdata;
    end
    if (vioOk) statusD[vioTarget] = 1'b1;
  end

  // pending: clear by write, record captured when bit clear after that
  always_comb begin
    pendCleared = pendQ;
    if (stb.wrPend) pendCleared = pendQ & ~stb.wdata[NUM_GROUPS-1:0];
    pendD   = pendCleared;
    capture = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (vioOk && vioGroup == g) begin
        pendD[g]   = 1'b1;
        capture[g] = !pendCleared[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      pendQ   <= '0;
      selQ    <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      pendQ   <= pendD;
      if (stb.wrSel) selQ <= stb.wdata[NUM_GROUPS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gRec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           recQ[g] <= '0;
      else if (capture[g]) recQ[g] <= newRec;
    end

    // R4: a pending record is neither replaced nor lost until cleared
    a_r4_record_kept: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[g] && !(stb.wrPend && stb.wdata[g])) |=> (pendQ[g] && $stable(recQ[g])));
  end

  // selected record lookup for the shift
  always_comb begin
    selRec = '0;
    selHit = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (selQ[g]) begin
        selRec = recQ[g];
        selHit = pendQ[g];
      end
    end
    if (!$onehot(selQ)) selHit = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbg0Q <= '0;
      dbg1Q <= '0;
    end else if (stb.shiftDone && selHit) begin
      dbg0Q <= packDbg0(selRec);
      dbg1Q <= selRec.addr[31:0];
    end
  end

  assign irq = |(statusQ & ~maskQ);

  always_comb begin
    dpRdata = '0;
    if (regAddr[1:0] == 2'b00) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regAddr[7:6] == 2'b00 && int'(regAddr[5:2]) == w)
          dpRdata = statusQ[w*32 +: 32];
        if (regAddr[7:6] == ADDR_MASK_BASE[7:6] && int'(regAddr[5:2]) == w)
          dpRdata = maskQ[w*32 +: 32];
      end
    end
    case (regAddr)
      ADDR_PEND: dpRdata = 32'(pendQ);
      ADDR_SEL:  dpRdata = 32'(selQ);
      ADDR_DBG0: dpRdata = dbg0Q;
      ADDR_DBG1: dpRdata = dbg1Q;
      default:   ;
    endcase
  end

  // R2: a violation always leaves its status bit set
  a_r2_vio_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    vioOk |=> statusQ[$past(vioTarget)]);

  // R7: debug words change only on a completing shift
  a_r7_dbg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftDone |=> ($stable(dbg0Q) && $stable(dbg1Q)));

  // R8: a shift with an unusable select leaves the debug words alone
  a_r8_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftDone && !(|(selQ & pendQ))) |=> ($stable(dbg0Q) && $stable(dbg1Q)));
endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int NUM_TARGETS  = 40,
  parameter int GROUP_SIZE   = 8,
  parameter int SHIFT_CYCLES = 32,
  localparam int TGT_W       = $clog2(NUM_TARGETS),
  localparam int NUM_WORDS   = (NUM_TARGETS + 31) / 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vioValid,
  input  logic [TGT_W-1:0]  vioTarget,
  input  logic [INIT_W-1:0] vioInitiator,
  input  logic [DOM_W-1:0]  vioDomain,
  input  logic              vioWrite,
  input  logic              vioRead,
  input  logic [ADDR_W-1:0] vioAddr,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  strobe_t     stb;
  logic [31:0] ctrlRdata, dpRdata;

  vcap_ctrl #(.NUM_WORDS(NUM_WORDS), .SHIFT_CYCLES(SHIFT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .stb(stb), .ctrlRdata(ctrlRdata)
  );

  vcap_dpath #(.NUM_TARGETS(NUM_TARGETS), .GROUP_SIZE(GROUP_SIZE)) u_dpath (
    .clk(clk), .rstN(rstN), .vioValid(vioValid), .vioTarget(vioTarget),
    .vioInitiator(vioInitiator), .vioDomain(vioDomain), .vioWrite(vioWrite),
    .vioRead(vioRead), .vioAddr(vioAddr), .stb(stb), .regAddr(regAddr),
    .dpRdata(dpRdata), .irq(irq)
  );

  assign regRdata = ctrlRdata | dpRdata;
endmodule

// File: tb/sim_vcap_top.sv
module sim_vcap_top;
  localparam int NT = 40;
  localparam int GS = 8;
  localparam int SC = 8;

  logic clk = 0, rstN = 0;
  logic vioValid = 0;
  logic [5:0] vioTarget = 0;
  logic [7:0] vioInitiator = 0;
  logic [3:0] vioDomain = 0;
  logic vioWrite = 0, vioRead = 0;
  logic [35:0] vioAddr = 0;
  logic regWrite = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic irq;
  int nChecks = 0, nErr = 0;
  bit finished = 0;
  logic [31:0] v;

  vcap_top #(.NUM_TARGETS(NT), .GROUP_SIZE(GS), .SHIFT_CYCLES(SC)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic inject(input int t, input logic [7:0] ini, input logic [3:0] dom,
                        input logic w, input logic r, input logic [35:0] ad);
    @(negedge clk);
    vioValid = 1; vioTarget = 6'(t); vioInitiator = ini; vioDomain = dom;
    vioWrite = w; vioRead = r; vioAddr = ad;
    @(negedge clk); vioValid = 0;
  endtask

  function automatic logic [31:0] expD0(logic [7:0] ini, logic [3:0] dom, logic w,
                                        logic r, logic [35:0] ad);
    return 32'(ini) | (32'(dom) << 8) | (32'(w) << 12) | (32'(r) << 13) |
           (32'(ad[35:32]) << 16);
  endfunction

  // start a shift and check both sides of the completion edge (R6)
  task automatic doShift(input string tag);
    logic [31:0] c;
    wr(8'h88, 1);
    repeat (SC - 1) @(negedge clk);
    rd(8'h88, c); chk({"R6 busy ", tag}, c, 32'h1);
    @(negedge clk);
    rd(8'h88, c); chk({"R6 done ", tag}, c, 32'h3);
  endtask

  task automatic stopShift();
    logic [31:0] c;
    wr(8'h88, 0);
    rd(8'h88, c); chk("R6 stop", c, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ini; logic [3:0] dom; logic [35:0] ad; logic w;
    logic [31:0] d0, d1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    foreach (v[i]) ;
    rd(8'h00, v); chk("R1 status0", v, 0);
    rd(8'h04, v); chk("R1 status1", v, 0);
    rd(8'h40, v); chk("R1 mask0", v, 0);
    rd(8'h80, v); chk("R1 pend", v, 0);
    rd(8'h84, v); chk("R1 sel", v, 0);
    rd(8'h88, v); chk("R1 ctrl", v, 0);
    rd(8'h8C, v); chk("R1 dbg0", v, 0);
    rd(8'h90, v); chk("R1 dbg1", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R5 select readback, only NUM_GROUPS bits
    wr(8'h84, 32'hFF); rd(8'h84, v); chk("R5 sel width", v, 32'h1F);
    wr(8'h84, 32'h04); rd(8'h84, v); chk("R5 sel value", v, 32'h04);

    // sweep every target: R2, R3, R4, R7
    for (int t = 0; t < NT; t++) begin
      int g;
      g = t / GS;
      ini = 8'(t * 5 + 3); dom = 4'(t); w = t[0];
      ad = {4'(t + 1), 32'hA000_0000 + 32'(t * 16)};
      inject(t, ini, dom, w, ~w, ad);
      rd(8'(4 * (t / 32)), v); chk("R2 status set", v, 32'h1 << (t % 32));
      chk("R3 irq raised", 32'(irq), 1);
      rd(8'h80, v); chk("R4 pend set", v, 32'h1 << g);
      wr(8'h84, 32'h1 << g);
      doShift("sweep");
      rd(8'h8C, v); chk("R7 dbg0", v, expD0(ini, dom, w, ~w, ad));
      rd(8'h90, v); chk("R7 dbg1", v, ad[31:0]);
      stopShift();
      wr(8'h80, 32'h1 << g); rd(8'h80, v); chk("R4 pend cleared", v, 0);
      wr(8'(4 * (t / 32)), 32'h1 << (t % 32));
      rd(8'(4 * (t / 32)), v); chk("R2 status cleared", v, 0);
      chk("R3 irq dropped", 32'(irq), 0);
    end

    // R3 masking
    inject(35, 8'h11, 4'h1, 1, 0, 36'h0_0000_0001);
    wr(8'h44, 32'h8); chk("R3 masked irq", 32'(irq), 0);
    rd(8'h04, v); chk("R3 status kept", v, 32'h8);
    wr(8'h44, 32'h0); chk("R3 unmasked irq", 32'(irq), 1);
    inject(1, 8'h12, 4'h2, 0, 1, 36'h0_0000_0002);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    chk("R3 all masked", 32'(irq), 0);
    wr(8'h40, 32'h0); chk("R3 word1 still masked", 32'(irq), 1);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h44, 0);
    wr(8'h80, 32'h1F);
    chk("R3 all cleared", 32'(irq), 0);

    // R4 second record in a pending group is dropped
    inject(9, 8'hA1, 4'h3, 1, 0, 36'h5_1111_0000);
    inject(10, 8'hB2, 4'h4, 0, 1, 36'h6_2222_0000);
    wr(8'h84, 32'h2); doShift("drop");
    rd(8'h8C, v); chk("R4 first kept dbg0", v, expD0(8'hA1, 4'h3, 1, 0, 36'h5_1111_0000));
    rd(8'h90, v); chk("R4 first kept dbg1", v, 32'h1111_0000);
    stopShift(); wr(8'h80, 32'h2);
    inject(11, 8'hC3, 4'h5, 1, 1, 36'h7_3333_0000);
    doShift("recapture");
    d0 = expD0(8'hC3, 4'h5, 1, 1, 36'h7_3333_0000);
    rd(8'h8C, v); chk("R4 recapture dbg0", v, d0);
    d1 = 32'h3333_0000;
    stopShift();

    // R8 unusable selects leave debug words alone (group 1 still pending)
    inject(2, 8'hD4, 4'h6, 0, 1, 36'h8_4444_0000);
    wr(8'h84, 0); doShift("sel zero");
    rd(8'h8C, v); chk("R8 zero sel dbg0", v, d0);
    rd(8'h90, v); chk("R8 zero sel dbg1", v, d1);
    stopShift();
    wr(8'h84, 32'h8); doShift("not pending");
    rd(8'h8C, v); chk("R8 idle group dbg0", v, d0);
    stopShift();
    wr(8'h84, 32'h3); doShift("two bits");
    rd(8'h90, v); chk("R8 multi sel dbg1", v, d1);
    stopShift();

    // R6 start while running or done is ignored
    wr(8'h84, 32'h1);
    wr(8'h88, 1);
    wr(8'h88, 1);
    repeat (SC - 3) @(negedge clk);
    rd(8'h88, v); chk("R6 restart no effect busy", v, 32'h1);
    @(negedge clk);
    rd(8'h88, v); chk("R6 restart no effect done", v, 32'h3);
    wr(8'h88, 1); rd(8'h88, v); chk("R6 start in done", v, 32'h3);
    rd(8'h90, v); chk("R7 group0 dbg1", v, 32'h4444_0000);
    stopShift();

    // R4 same-cycle clear and new violation: stored, bit stays
    @(negedge clk);
    vioValid = 1; vioTarget = 3; vioInitiator = 8'hE5; vioDomain = 4'h7;
    vioWrite = 1; vioRead = 0; vioAddr = 36'h9_5555_0000;
    regWrite = 1; regAddr = 8'h80; regWdata = 32'h1;
    @(negedge clk); vioValid = 0; regWrite = 0;
    rd(8'h80, v); chk("R4 same-cycle pend", v, 32'h3);
    doShift("same cycle");
    rd(8'h8C, v); chk("R4 same-cycle dbg0", v, expD0(8'hE5, 4'h7, 1, 0, 36'h9_5555_0000));
    stopShift();

    // R2 same-cycle status clear and violation: set wins
    @(negedge clk);
    vioValid = 1; vioTarget = 4;
    regWrite = 1; regAddr = 8'h00; regWdata = 32'h10;
    @(negedge clk); vioValid = 0; regWrite = 0;
    rd(8'h00, v); chk("R2 set wins", v & 32'h10, 32'h10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule